// File: doc/BRIEF.md
# MDIO management frame target

This block is a serial management slave clocked by MDC. It watches a shared, bidirectional MDIO line for frames from a management station and gives the station access to a small bank of generic 16-bit read/write registers. Each frame is parsed one bit per rising MDC edge. The fields are the preamble, the start pattern, the opcode, the 5-bit PHY address, the 5-bit register address, a two-bit turnaround and 16 data bits. On a read, the block takes over the line during the second turnaround bit and shifts the register contents out. On a write, it loads the addressed register when the last data bit arrives.

The pad is outside the block. The block presents separate input, output and output-enable signals, and the pad combines them into the tri-state line. The block accepts frames back to back with no idle bit between them. A read from a register address that has no register returns all ones. A write to such an address changes nothing. The register contents are also presented flat on a register-file output for the surrounding logic.

Top module: `mdio_target`

## Requirements
- R1: While reset is asserted and after it is released, `mdio_oe_o` is 0 and every register reads 0000h.
- R2: A frame is accepted only after at least 32 consecutive sampled ones followed by the start bits 0 then 1. A shorter run of ones causes the whole frame to be ignored, and the parser recovers for the next proper frame.
- R3: The first opcode bit is the MSB. Opcode 10b is a read and 01b is a write. A frame with 00b or 11b is abandoned: the line is not driven and no register changes.
- R4: The 5-bit PHY address, sent MSB first, must equal `phy_addr_i`. For any other address the block never drives the line and modifies no register.
- R5: On a matched read, `mdio_oe_o` stays 0 during the first turnaround bit. During the second turnaround bit, `mdio_oe_o` is 1 and `mdio_o` is 0.
- R6: On a matched read, the 16 data bits follow the turnaround MSB first. Each bit is updated just after a rising MDC edge. `mdio_oe_o` is high for exactly 17 bit times and falls right after the last data bit.
- R7: On a matched write, the 16 data bits, sent MSB first, are stored in the register selected by the 5-bit register address (sent MSB first). The new value appears on `regs_o`, where register k occupies bits [16k+15:16k].
- R8: A read of a register address of 4 or more (no register there) returns FFFFh.
- R9: A write to a register address of 4 or more leaves every register unchanged.
- R10: A new frame's preamble may begin on the bit right after the previous frame's last data bit, with no idle bit in between.
- R11: Whenever the block is between frames, or hunting for a preamble, or inside the start, opcode or address fields, `mdio_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc_i | input | 1 | Management clock; MDIO is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phy_addr_i | input | 5 | PHY address this target answers to |
| mdio_i | input | 1 | Sampled level of the MDIO line |
| mdio_o | output | 1 | Value driven onto MDIO when enabled |
| mdio_oe_o | output | 1 | Output enable for the MDIO pad; 0 leaves the line high-impedance |
| regs_o | output | 64 | Register-file contents, register k in bits [16k+15:16k] |

## Verification
The bench targets the turnaround handoff. A target that drives during the first turnaround bit would fight the station, and one that drives too late shows no zero in the second bit. It counts every bit time in which the line is enabled, so a release one bit late or early, or any drive on a foreign PHY address or a bad opcode, shows up as a count other than 17 or 0. It sends frames with a 31-bit preamble and with illegal opcodes, and reads back the registers afterwards. This shows a parser that locks on too early, or lets a broken frame through as a write. It also runs frames with no idle gap and reads and writes at unmapped addresses, which catch a parser that needs an idle bit to resync and a decoder that folds high addresses onto real registers.

// File: rtl/mdio_target_pkg.sv
package mdio_target_pkg;
  localparam int PHY_AW   = 5;
  localparam int REG_AW   = 5;
  localparam int ADDR_LEN = PHY_AW + REG_AW;
  localparam int TA_LEN   = 2;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  typedef enum logic [2:0] {
    ST_PRE,
    ST_SOF,
    ST_OP,
    ST_ADDR,
    ST_TA,
    ST_DATA
  } frame_state_e;
endpackage

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [DATA_W-1:0]          rd_data_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);

  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    // addresses at or above NUM_REGS select no register
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= '0;
      end else if (wr_en_i && (wr_addr_i == ADDR_W'(g))) begin
        regs_q[g] <= wr_data_i;
      end
    end
    assign regs_o[g*DATA_W +: DATA_W] = regs_q[g];
  end

  always_comb begin
    rd_data_o = '1;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr_i == ADDR_W'(i)) rd_data_o = regs_q[i];
    end
  end

endmodule

// File: rtl/mdio_frame_parser.sv
module mdio_frame_parser
  import mdio_target_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic               mdc_i,
  input  logic               rst_ni,
  input  logic               mdio_i,
  input  logic [PHY_AW-1:0]  phy_addr_i,
  output frame_state_e       state_o,
  output logic               rd_load_o,
  output logic [REG_AW-1:0]  rd_addr_o,
  output logic               ta_drive_o,
  output logic               shift_o,
  output logic               release_o,
  output logic               wr_en_o,
  output logic [REG_AW-1:0]  wr_addr_o,
  output logic [DATA_W-1:0]  wr_data_o
);

  localparam int CNT_MAX0 = (PRE_LEN > DATA_W) ? PRE_LEN : DATA_W;
  localparam int CNT_MAX  = (CNT_MAX0 > ADDR_LEN) ? CNT_MAX0 : ADDR_LEN;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  frame_state_e            state_q;
  logic [CNT_W-1:0]        cnt_q;
  logic                    op_hi_q;
  logic                    is_rd_q;
  logic                    hit_q;
  logic [ADDR_LEN-2:0]     addr_sh_q;
  logic [DATA_W-2:0]       data_sh_q;

  logic [1:0]              op_full;
  logic [ADDR_LEN-1:0]     addr_full;
  logic                    phy_hit;
  logic                    addr_last;
  logic                    data_last;

  assign op_full   = {op_hi_q, mdio_i};
  assign addr_full = {addr_sh_q, mdio_i};
  assign phy_hit   = (addr_full[ADDR_LEN-1 -: PHY_AW] == phy_addr_i);
  assign addr_last = (state_q == ST_ADDR) && (cnt_q == CNT_W'(ADDR_LEN - 1));
  assign data_last = (state_q == ST_DATA) && (cnt_q == CNT_W'(DATA_W - 1));

  always_ff @(posedge mdc_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_PRE;
      cnt_q     <= '0;
      op_hi_q   <= 1'b0;
      is_rd_q   <= 1'b0;
      hit_q     <= 1'b0;
      addr_sh_q <= '0;
      data_sh_q <= '0;
    end else begin
      unique case (state_q)
        ST_PRE: begin
          if (mdio_i) begin
            if (cnt_q != CNT_W'(PRE_LEN)) cnt_q <= cnt_q + 1'b1;
          end else begin
            if (cnt_q == CNT_W'(PRE_LEN)) state_q <= ST_SOF;
            cnt_q <= '0;
          end
        end
        ST_SOF: begin
          state_q <= mdio_i ? ST_OP : ST_PRE;
          cnt_q   <= '0;
        end
        ST_OP: begin
          op_hi_q <= mdio_i;
          if (cnt_q == CNT_W'(1)) begin
            cnt_q   <= '0;
            is_rd_q <= (op_full == OP_RD);
            state_q <= (op_full == OP_RD || op_full == OP_WR) ? ST_ADDR : ST_PRE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ADDR: begin
          addr_sh_q <= addr_full[ADDR_LEN-2:0];
          if (addr_last) begin
            cnt_q   <= '0;
            hit_q   <= phy_hit;
            state_q <= ST_TA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_TA: begin
          if (cnt_q == CNT_W'(TA_LEN - 1)) begin
            cnt_q   <= '0;
            state_q <= ST_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          data_sh_q <= {data_sh_q[DATA_W-3:0], mdio_i};
          if (data_last) begin
            cnt_q   <= '0;
            state_q <= ST_PRE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          cnt_q   <= '0;
          state_q <= ST_PRE;
        end
      endcase
    end
  end

  logic rd_hit;
  assign rd_hit = hit_q && is_rd_q;

  assign state_o    = state_q;
  assign rd_load_o  = addr_last && is_rd_q && phy_hit;
  assign rd_addr_o  = addr_full[REG_AW-1:0];
  assign ta_drive_o = rd_hit && (state_q == ST_TA) && (cnt_q == '0);
  assign shift_o    = rd_hit && (((state_q == ST_TA) && (cnt_q == CNT_W'(TA_LEN - 1)))
                                 || ((state_q == ST_DATA) && !data_last));
  assign release_o  = rd_hit && data_last;
  assign wr_en_o    = hit_q && !is_rd_q && data_last;
  assign wr_addr_o  = addr_sh_q[REG_AW-1:0];
  assign wr_data_o  = {data_sh_q, mdio_i};

endmodule

// File: rtl/mdio_read_driver.sv
module mdio_read_driver #(
  parameter int DATA_W = 16
) (
  input  logic              mdc_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              ta_drive_i,
  input  logic              shift_i,
  input  logic              release_i,
  output logic              mdio_o,
  output logic              mdio_oe_o
);

  logic [DATA_W-1:0] sh_q;
  logic              out_q;
  logic              oe_q;

  always_ff @(posedge mdc_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      if (load_i) sh_q <= rd_data_i;
      if (ta_drive_i) begin
        oe_q  <= 1'b1;
        out_q <= 1'b0;
      end
      if (shift_i) begin
        out_q <= sh_q[DATA_W-1];
        sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
      end
      if (release_i) begin
        oe_q  <= 1'b0;
        out_q <= 1'b0;
      end
    end
  end

  assign mdio_o    = out_q;
  assign mdio_oe_o = oe_q;

endmodule

// File: rtl/mdio_target.sv
module mdio_target
  import mdio_target_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 4,
  parameter int PRE_LEN  = 32
) (
  input  logic                       mdc_i,
  input  logic                       rst_ni,
  input  logic [PHY_AW-1:0]          phy_addr_i,
  input  logic                       mdio_i,
  output logic                       mdio_o,
  output logic                       mdio_oe_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);

  frame_state_e      frame_state;
  logic              rd_load;
  logic [REG_AW-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              ta_drive;
  logic              shift_en;
  logic              release_en;
  logic              wr_en;
  logic [REG_AW-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  mdio_frame_parser #(
    .DATA_W  (DATA_W),
    .PRE_LEN (PRE_LEN)
  ) u_parser (
    .mdc_i      (mdc_i),
    .rst_ni     (rst_ni),
    .mdio_i     (mdio_i),
    .phy_addr_i (phy_addr_i),
    .state_o    (frame_state),
    .rd_load_o  (rd_load),
    .rd_addr_o  (rd_addr),
    .ta_drive_o (ta_drive),
    .shift_o    (shift_en),
    .release_o  (release_en),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data)
  );

  mdio_reg_bank #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (REG_AW)
  ) u_bank (
    .clk_i     (mdc_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .regs_o    (regs_o)
  );

  mdio_read_driver #(
    .DATA_W (DATA_W)
  ) u_drv (
    .mdc_i      (mdc_i),
    .rst_ni     (rst_ni),
    .load_i     (rd_load),
    .rd_data_i  (rd_data),
    .ta_drive_i (ta_drive),
    .shift_i    (shift_en),
    .release_i  (release_en),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o)
  );

endmodule

// File: rtl/mdio_target_chk.sv
module mdio_target_chk
  import mdio_target_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 4
) (
  input logic                       mdc_i,
  input logic                       rst_ni,
  input logic                       mdio_o,
  input logic                       mdio_oe_o,
  input frame_state_e               state_i,
  input logic                       wr_en_i,
  input logic [REG_AW-1:0]          wr_addr_i,
  input logic [NUM_REGS*DATA_W-1:0] regs_i
);

  logic [7:0] oe_run_q;

  always_ff @(posedge mdc_i or negedge rst_ni) begin
    if (!rst_ni)             oe_run_q <= '0;
    else if (!mdio_oe_o)     oe_run_q <= '0;
    else if (oe_run_q != '1) oe_run_q <= oe_run_q + 1'b1;
  end

  p_idle_tristate_r11: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    (state_i inside {ST_PRE, ST_SOF, ST_OP, ST_ADDR}) |-> !mdio_oe_o);

  p_ta_zero_r5: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    $rose(mdio_oe_o) |-> (!mdio_o && state_i == ST_TA));

  p_drive_len_r6: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    $fell(mdio_oe_o) |-> (oe_run_q == 8'(DATA_W + 1)));

  p_unmapped_wr_r9: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    (wr_en_i && int'(wr_addr_i) >= NUM_REGS) |=> $stable(regs_i));

  p_oe_known_r1: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    !$isunknown(mdio_oe_o));

endmodule

bind mdio_target mdio_target_chk #(
  .DATA_W   (DATA_W),
  .NUM_REGS (NUM_REGS)
) u_chk (
  .mdc_i     (mdc_i),
  .rst_ni    (rst_ni),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o),
  .state_i   (frame_state),
  .wr_en_i   (wr_en),
  .wr_addr_i (wr_addr),
  .regs_i    (regs_o)
);

// File: tb/mdio_target_test.sv
`timescale 1ns/1ps
module mdio_target_test;
  localparam logic [4:0] MY_PHY    = 5'h0B;
  localparam logic [4:0] OTHER_PHY = 5'h03;
  localparam int         NV        = 14;

  // {op[48:47], phy[46:42], reg[41:37], wdata[36:21], exp[20:5], drive[4], tag[3:0]}
  localparam logic [48:0] VECS [0:NV-1] = '{
    {2'b01, MY_PHY,    5'd0,  16'hA5C3, 16'h0000, 1'b0, 4'd7},
    {2'b01, MY_PHY,    5'd1,  16'h1234, 16'h0000, 1'b0, 4'd7},
    {2'b01, MY_PHY,    5'd3,  16'h8001, 16'h0000, 1'b0, 4'd7},
    {2'b10, MY_PHY,    5'd0,  16'h0000, 16'hA5C3, 1'b1, 4'd6},
    {2'b10, MY_PHY,    5'd1,  16'h0000, 16'h1234, 1'b1, 4'd6},
    {2'b10, MY_PHY,    5'd3,  16'h0000, 16'h8001, 1'b1, 4'd7},
    {2'b10, MY_PHY,    5'd2,  16'h0000, 16'h0000, 1'b1, 4'd1},
    {2'b10, MY_PHY,    5'd9,  16'h0000, 16'hFFFF, 1'b1, 4'd8},
    {2'b01, MY_PHY,    5'd9,  16'hDEAD, 16'h0000, 1'b0, 4'd9},
    {2'b10, MY_PHY,    5'd0,  16'h0000, 16'hA5C3, 1'b1, 4'd9},
    {2'b01, OTHER_PHY, 5'd0,  16'h0BAD, 16'h0000, 1'b0, 4'd4},
    {2'b10, OTHER_PHY, 5'd0,  16'h0000, 16'h0000, 1'b0, 4'd4},
    {2'b10, MY_PHY,    5'd0,  16'h0000, 16'hA5C3, 1'b1, 4'd4},
    {2'b10, MY_PHY,    5'd31, 16'h0000, 16'hFFFF, 1'b1, 4'd8}
  };

  logic        mdc = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdio_in = 1'b1;
  logic        mdio_out;
  logic        mdio_oe;
  logic [63:0] regs;

  int checks = 0;
  int fails  = 0;

  logic        o_first_oe;
  int          o_drive_cnt;
  logic        o_ta_ok;
  logic [15:0] o_rdata;

  always #5 mdc = ~mdc;

  mdio_target uut (
    .mdc_i      (mdc),
    .rst_ni     (rst_n),
    .phy_addr_i (MY_PHY),
    .mdio_i     (mdio_in),
    .mdio_o     (mdio_out),
    .mdio_oe_o  (mdio_oe),
    .regs_o     (regs)
  );

  function automatic string tag_name(input int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one bit time: observe what the target drives for this bit, then present the station bit
  task automatic bit_time(input logic b, output logic oe, output logic o);
    @(negedge mdc);
    oe = mdio_oe;
    o  = mdio_out;
    mdio_in = b;
  endtask

  task automatic run_frame(input int pre, input logic [1:0] op, input logic [4:0] phy,
                           input logic [4:0] ra, input logic [15:0] wd);
    logic oe, o, ta1_oe, ta2_oe, ta2_o;
    logic is_rd;
    is_rd = (op == 2'b10);
    o_drive_cnt = 0;
    o_rdata = '0;
    for (int i = 0; i < pre; i++) begin
      bit_time(1'b1, oe, o);
      if (i == 0) o_first_oe = oe;
      if (oe) o_drive_cnt++;
    end
    bit_time(1'b0, oe, o); if (oe) o_drive_cnt++;
    bit_time(1'b1, oe, o); if (oe) o_drive_cnt++;
    for (int i = 1; i >= 0; i--) begin bit_time(op[i], oe, o); if (oe) o_drive_cnt++; end
    for (int i = 4; i >= 0; i--) begin bit_time(phy[i], oe, o); if (oe) o_drive_cnt++; end
    for (int i = 4; i >= 0; i--) begin bit_time(ra[i], oe, o); if (oe) o_drive_cnt++; end
    bit_time(1'b1, ta1_oe, o);
    if (ta1_oe) o_drive_cnt++;
    bit_time(is_rd ? 1'b1 : 1'b0, ta2_oe, ta2_o);
    if (ta2_oe) o_drive_cnt++;
    o_ta_ok = !ta1_oe && ta2_oe && !ta2_o;
    for (int i = 15; i >= 0; i--) begin
      bit_time(is_rd ? 1'b1 : wd[i], oe, o);
      if (oe) o_drive_cnt++;
      o_rdata[i] = o;
    end
  endtask

  task automatic check_read(input string tag, input logic [15:0] exp);
    check(o_first_oe == 1'b0, "R11", "line released before frame", 64'(o_first_oe), 64'd0);
    check(o_drive_cnt == 17, "R6", "drive bit times", 64'(o_drive_cnt), 64'd17);
    check(o_ta_ok, "R5", "turnaround Z then 0", 64'(o_ta_ok), 64'd1);
    check(o_rdata == exp, tag, "read data", 64'(o_rdata), 64'(exp));
  endtask

  task automatic check_silent(input string tag);
    check(o_drive_cnt == 0, tag, "line driven during frame", 64'(o_drive_cnt), 64'd0);
  endtask

  initial begin
    logic oe_d, o_d;
    repeat (3) @(negedge mdc);
    check(mdio_oe == 1'b0, "R1", "oe in reset", 64'(mdio_oe), 64'd0);
    check(regs == 64'd0, "R1", "regs in reset", regs, 64'd0);
    rst_n = 1'b1;
    @(negedge mdc);
    check(mdio_oe == 1'b0, "R1", "oe after reset", 64'(mdio_oe), 64'd0);

    for (int v = 0; v < NV; v++) begin
      logic [48:0] e;
      e = VECS[v];
      run_frame(32, e[48:47], e[46:42], e[41:37], e[36:21]);
      if (e[4]) check_read(tag_name(int'(e[3:0])), e[20:5]);
      else      check_silent(tag_name(int'(e[3:0])));
    end

    // R2: 31-bit preamble is rejected, then a full frame still works
    bit_time(1'b0, oe_d, o_d);
    run_frame(31, 2'b10, MY_PHY, 5'd0, 16'h0000);
    check_silent("R2");
    run_frame(32, 2'b10, MY_PHY, 5'd0, 16'h0000);
    check_read("R2", 16'hA5C3);
    run_frame(40, 2'b10, MY_PHY, 5'd1, 16'h0000);
    check_read("R2", 16'h1234);

    // R3: illegal opcodes carry data for reg0 but must not write or drive
    run_frame(32, 2'b00, MY_PHY, 5'd0, 16'h0000);
    check_silent("R3");
    run_frame(32, 2'b11, MY_PHY, 5'd0, 16'h0000);
    check_silent("R3");
    run_frame(32, 2'b10, MY_PHY, 5'd0, 16'h0000);
    check_read("R3", 16'hA5C3);

    // R10: write then read with no idle bit between the frames
    run_frame(32, 2'b01, MY_PHY, 5'd2, 16'h5A5A);
    check_silent("R10");
    run_frame(32, 2'b10, MY_PHY, 5'd2, 16'h0000);
    check_read("R10", 16'h5A5A);
    check(regs[47:32] == 16'h5A5A, "R7", "register-file port reg2", 64'(regs[47:32]), 64'h5A5A);
    check(regs[15:0] == 16'hA5C3, "R9", "reg0 untouched", 64'(regs[15:0]), 64'hA5C3);

    @(negedge mdc);
    check(mdio_oe == 1'b0, "R6", "released after last data bit", 64'(mdio_oe), 64'd0);

    // R1: reset clears the registers again
    rst_n = 1'b0;
    @(negedge mdc);
    check(regs == 64'd0, "R1", "regs after second reset", regs, 64'd0);
    check(mdio_oe == 1'b0, "R1", "oe after second reset", 64'(mdio_oe), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule